// File: doc/BRIEF.md
# Offset-Cancelling Successive Approximation Controller

This block is the digital sequencer of a 10-bit successive approximation converter. A start pulse launches a conversion. The block drives a trial code to the conversion DAC one bit per clock, starting at the MSB. It reads back a single comparator bit and settles on a final code. When the autozero input is low at start, that single result is the output.

When autozero is requested, the block runs two conversions back to back. The first result (OC1) is written to a second DAC, and twice its value is saved. The comparator source is then switched from the external input to that second DAC, and the re-created voltage is converted (OC2). A constant comparator offset appears once in OC1 and twice in OC2, so the output `2*OC1 - OC2` removes it. A stall counter returns the sequencer to idle if it ever stops changing state, for example after an upset in a state flop.

Top module: `az_sar_ctrl`

## Requirements
- R1: Reset state. After synchronous reset all outputs are zero: `busy_o`, `done_o`, `src_sel_o`, `code_o`, `trial_code_o` and `azdac_code_o`.
- R2: Plain conversion timing.
  - With `az_en_i` low at start, one conversion runs.
  - `done_o` rises after the 12th rising edge that follows the edge sampling `start_i`.
  - `code_o` is then that conversion's result.
  - `src_sel_o` stays 0, where 0 selects the external input and 1 selects the autozero DAC.
- R3: Bit resolution. The first trial code is 1 followed by nine zeros (512). Each clock, the bit under test is kept when `cmp_i` is 1, meaning the input is at or above the DAC level, and cleared otherwise. The next lower bit is then set. For an input x (in LSB) the result is therefore x clipped to 0..1023.
- R4: Autozero sequencing.
  - With `az_en_i` high at start, a second conversion follows the first.
  - During the second conversion `src_sel_o` is 1 and `azdac_code_o` holds OC1.
  - `done_o` rises after the 26th edge following the start edge.
- R5: In autozero mode `code_o` equals `2*OC1 - OC2`, which cancels a constant comparator offset.
- R6: The difference is formed at 12-bit signed width and saturated to the range 0..1023.
- R7: A start pulse is ignored while busy. This includes the cycle in which `done_o` is high.
- R8: `done_o` is high for exactly one cycle. `code_o` changes only in a cycle where `done_o` is high.
- R9: If no state transition occurs for 64 clocks, the sequencer returns to idle without asserting `done_o`. The next start then works normally.
- R10: `az_en_i` is sampled only with an accepted start. Changing it mid-conversion has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| az_en_i | input | 1 | Request offset-cancelling double conversion |
| cmp_i | input | 1 | Comparator: 1 = selected source at or above trial level |
| trial_code_o | output | 10 | Trial code to the conversion DAC |
| azdac_code_o | output | 10 | Code held on the autozero DAC |
| src_sel_o | output | 1 | Comparator source: 0 external input, 1 autozero DAC |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 10 | Final result, held until next done |

## Verification
A new start and the completion pulse can fall in the same cycle. The bench provokes this by pulsing `start_i` in exactly the cycle it sees `done_o` high. It then checks that no second conversion follows: no further done, and `busy_o` low. A start during the first conversion, together with a change of `az_en_i`, is judged in the same run. The latency must stay at the plain value and the code must match the plain result.

// File: rtl/sar_az_pkg.sv
package sar_az_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CONV1    = 3'd1,
    ST_LOAD_AZ  = 3'd2,
    ST_CONV2    = 3'd3,
    ST_SUBTRACT = 3'd4,
    ST_DONE     = 3'd5
  } sar_state_e;
endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort_i,
  input  logic         go_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         fin_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  trial_q;
  logic [IW-1:0] idx_q;
  logic          active_q;
  logic          fin_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      trial_q  <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        trial_q  <= W'(1) << (W - 1);
        idx_q    <= IW'(W - 1);
        active_q <= 1'b1;
      end else if (active_q) begin
        if (!cmp_i) trial_q[idx_q] <= 1'b0;
        if (idx_q == '0) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end else begin
          trial_q[idx_q - 1'b1] <= 1'b1;
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign trial_o = trial_q;
  assign fin_o   = fin_q;

  // R3: the finish flag is a single-cycle event
  p_fin_single_r3: assert property (@(posedge clk) disable iff (rst || abort_i)
    fin_q |=> !fin_q);

  // R3: the first trial of a conversion is the MSB alone
  p_trial_msb_r3: assert property (@(posedge clk) disable iff (rst || abort_i)
    go_i |=> (trial_q == (W'(1) << (W - 1))));
endmodule

// File: rtl/az_offset_sub.sv
module az_offset_sub #(
  parameter int W = 10
) (
  input  logic [W:0]   dbl_i,
  input  logic [W-1:0] oc2_i,
  output logic [W-1:0] res_o
);
  localparam int SW = W + 2;

  logic [SW-1:0] lhs;
  logic [SW-1:0] rhs;
  logic [SW-1:0] diff;

  assign lhs  = {1'b0, dbl_i};
  assign rhs  = {2'b00, oc2_i};
  assign diff = lhs - rhs;

  always_comb begin
    if (diff[SW-1])               res_o = '0;
    else if (diff[SW-2:W] != '0)  res_o = '1;
    else                          res_o = diff[W-1:0];
  end
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic reload_i,
  output logic trip_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign trip_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || reload_i || trip_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // R9: the stall counter never passes its limit
  p_wd_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/az_sar_ctrl.sv
module az_sar_ctrl
  import sar_az_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int WD_LIMIT  = 64,
  parameter int AZ_SETTLE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              az_en_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_code_o,
  output logic [DATA_W-1:0] azdac_code_o,
  output logic              src_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] code_o
);
  localparam int STW = (AZ_SETTLE > 1) ? $clog2(AZ_SETTLE) : 1;

  sar_state_e        state_q, state_d;
  logic              go_q, go_d;
  logic              az_q;
  logic [DATA_W:0]   dbl_q;
  logic [DATA_W-1:0] azdac_q;
  logic              src_q;
  logic [DATA_W-1:0] sat_q;
  logic [DATA_W-1:0] code_q;
  logic              done_q;
  logic [STW-1:0]    settle_q;

  logic [DATA_W-1:0] eng_trial;
  logic              eng_fin;
  logic [DATA_W-1:0] sub_res;
  logic              wd_trip;
  logic              wd_reload;

  sar_bit_engine #(.W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .abort_i (wd_trip),
    .go_i    (go_q),
    .cmp_i   (cmp_i),
    .trial_o (eng_trial),
    .fin_o   (eng_fin)
  );

  az_offset_sub #(.W(DATA_W)) u_sub (
    .dbl_i (dbl_q),
    .oc2_i (eng_trial),
    .res_o (sub_res)
  );

  assign wd_reload = (state_q == ST_IDLE) || (state_d != state_q);

  stall_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk      (clk),
    .rst      (rst),
    .reload_i (wd_reload),
    .trip_o   (wd_trip)
  );

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (start_i) begin state_d = ST_CONV1; go_d = 1'b1; end
      ST_CONV1:    if (eng_fin) state_d = az_q ? ST_LOAD_AZ : ST_DONE;
      ST_LOAD_AZ:  if (settle_q == STW'(AZ_SETTLE - 1)) begin
                     state_d = ST_CONV2;
                     go_d    = 1'b1;
                   end
      ST_CONV2:    if (eng_fin) state_d = ST_SUBTRACT;
      ST_SUBTRACT: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    if (wd_trip) begin
      state_d = ST_IDLE;
      go_d    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      go_q     <= 1'b0;
      az_q     <= 1'b0;
      dbl_q    <= '0;
      azdac_q  <= '0;
      src_q    <= 1'b0;
      sat_q    <= '0;
      code_q   <= '0;
      done_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      go_q     <= go_d;
      done_q   <= (state_d == ST_DONE);
      src_q    <= (state_d == ST_LOAD_AZ) || (state_d == ST_CONV2);
      settle_q <= (state_q == ST_LOAD_AZ) ? settle_q + 1'b1 : '0;
      if (state_q == ST_IDLE && start_i) az_q <= az_en_i;
      if (!wd_trip) begin
        if (state_q == ST_CONV1 && eng_fin) begin
          dbl_q   <= {eng_trial, 1'b0};
          azdac_q <= eng_trial;
          if (!az_q) code_q <= eng_trial;
        end
        if (state_q == ST_CONV2 && eng_fin) sat_q  <= sub_res;
        if (state_q == ST_SUBTRACT)         code_q <= sat_q;
      end
    end
  end

  assign trial_code_o = eng_trial;
  assign azdac_code_o = azdac_q;
  assign src_sel_o    = src_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign code_o       = code_q;

  // R8: completion pulse lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: the result only moves together with the completion pulse
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(code_q));

  // R4: second conversion sees the autozero DAC, whose code is frozen
  p_src_conv2_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV2) |-> (src_q && $stable(azdac_q)));

  // R2: first conversion always reads the external input
  p_src_conv1_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV1) |-> !src_q);

  // R7: a start during the first conversion does not disturb it
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV1 && start_i && !eng_fin && !wd_trip) |=> (state_q == ST_CONV1));
endmodule

// File: tb/az_sar_ctrl_bench.sv
module az_sar_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int LAT_PLAIN = 13;
  localparam int LAT_AZ = 27;

  // stimulus: input level, comparator offset for source 0 and source 1, mode; expected code
  localparam int T_VIN [NV] = '{500, 500, 500, 300,   0, 1023, 1000,  10, 683,  85, 1023,  1};
  localparam int T_OFA [NV] = '{  0,   7,   7,  -9,   0,    0,    0,   0,  12,  -3,    4, -2};
  localparam int T_OFB [NV] = '{  0,   7,   7,  -9,   0,    0, -100, 100,  12,  -3,    4, -2};
  localparam bit T_AZ  [NV] = '{  0,   0,   1,   1,   0,    1,    1,   1,   1,   0,    1,  1};
  localparam int T_EXP [NV] = '{500, 507, 500, 300,   0, 1023, 1023,   0, 683,  82, 1023,  0};
  localparam int T_OC1 [NV] = '{500, 507, 507, 291,   0, 1023, 1000,  10, 695,  82, 1023,  0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic az_en = 1'b0;
  logic cmp;
  logic [9:0] trial, azdac, code;
  logic src_sel, busy, done;

  int vin_r = 0;
  int offa = 0;
  int offb = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (((src_sel ? int'(azdac) : vin_r) + (src_sel ? offb : offa)) >= int'(trial));

  az_sar_ctrl u_az_sar_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .az_en_i      (az_en),
    .cmp_i        (cmp),
    .trial_code_o (trial),
    .azdac_code_o (azdac),
    .src_sel_o    (src_sel),
    .busy_o       (busy),
    .done_o       (done),
    .code_o       (code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int vin, input int oa, input int ob, input bit az,
                          output int res, output int lat, output int azseen, output int srcseen);
    vin_r = vin; offa = oa; offb = ob; az_en = az;
    azseen = -1; srcseen = 0;
    start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 200) begin
      if (src_sel) begin azseen = int'(azdac); srcseen = 1; end
      @(posedge clk); lat++;
      @(negedge clk);
    end
    res = int'(code);
  endtask

  initial begin
    int res, lat, azs, srcs, held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    check(!busy && !done && !src_sel, "R1 flags", {busy, done, src_sel}, 0);
    check(code == 0 && trial == 0 && azdac == 0, "R1 codes", int'(code) + int'(trial) + int'(azdac), 0);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      run_conv(T_VIN[i], T_OFA[i], T_OFB[i], T_AZ[i], res, lat, azs, srcs);
      check(res == T_EXP[i], T_AZ[i] ? "R5/R6 corrected code" : "R2/R3 plain code", res, T_EXP[i]);
      if (T_AZ[i]) begin
        check(lat == LAT_AZ, "R4 latency", lat, LAT_AZ);
        check(azs == T_OC1[i], "R4 azdac holds OC1", azs, T_OC1[i]);
      end else begin
        check(lat == LAT_PLAIN, "R2 latency", lat, LAT_PLAIN);
        check(srcs == 0, "R2 source stays external", srcs, 0);
      end
      held = int'(code);
      @(posedge clk); @(negedge clk);
      check(!done, "R8 done one cycle", done, 0);
      repeat (3) begin @(posedge clk); @(negedge clk); end
      check(int'(code) == held, "R8 code held", int'(code), held);
    end

    // R7 and R10: start mid-conversion with mode change, and start in the done cycle
    begin
      int ndone, first;
      ndone = 0; first = 0;
      vin_r = 200; offa = 0; offb = 50; az_en = 1'b0;
      start = 1'b1;
      for (int i = 1; i <= 40; i++) begin
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (i == 4) begin start = 1'b1; az_en = 1'b1; end
        if (done) begin
          ndone++;
          if (ndone == 1) begin
            first = i;
            check(int'(code) == 200, "R10 plain result despite mode change", int'(code), 200);
            start = 1'b1;
          end
        end
      end
      check(first == LAT_PLAIN, "R7/R10 latency unchanged", first, LAT_PLAIN);
      check(ndone == 1, "R7 start during busy and done ignored", ndone, 1);
      check(!busy, "R7 idle after ignored starts", busy, 0);
      az_en = 1'b0;
    end

    // R9: stalled sequencer is returned to idle
    begin
      int cyc, sawdone;
      cyc = 0; sawdone = 0;
      vin_r = 300; offa = 0; offb = 0; az_en = 1'b0;
      start = 1'b1;
      @(posedge clk); cyc = 1;
      @(negedge clk); start = 1'b0;
      force u_az_sar_ctrl.eng_fin = 1'b0;
      while (busy && cyc < 150) begin
        @(posedge clk); cyc++;
        @(negedge clk);
        if (done) sawdone = 1;
      end
      release u_az_sar_ctrl.eng_fin;
      check(cyc >= 60 && cyc <= 70, "R9 stall recovery time", cyc, 65);
      check(sawdone == 0, "R9 no done on stall", sawdone, 0);
      check(!src_sel, "R9 source external after stall", src_sel, 0);
      run_conv(321, 3, 3, 1'b1, res, lat, azs, srcs);
      check(res == 321, "R9 conversion after recovery", res, 321);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule